// File: doc/BRIEF.md
# CPU Interrupt Acknowledge Sequencer

This block is the interrupt control unit of an 8-bit processor core. It keeps the two interrupt-enable flip-flops, the interrupt-mode register and a latch that remembers a falling edge on the non-maskable request line. At every instruction boundary reported by the decoder it decides whether to take a non-maskable request, a maskable request, or nothing. It then steps through the acknowledge machine cycles one T-state per clock. Each machine cycle is reported by kind and T-state index. The block strobes out the two return-address bytes for the stack. For the vectored mode it presents the table addresses to read. When the sequence is over it delivers the new program counter.

The decoder tells the block when an instruction ends and whether the byte just finished was an index-register prefix. It also strobes enable, disable, return-from-interrupt and mode-select commands. The block samples the interrupt-vector base register and the data bus only while it is acknowledging. Instruction decode and the memory interface are outside the block. The one-instruction shadow after an enable command comes from the ordering rules at the boundary.

Top module: `irq_ack_seq`

## Requirements
- R1: After reset both enable flags are 0, the mode is 0, `busy` is 0, `cyc_kind` is 0 and `t_state` is 0.
- R2: `ei_stb` sets both `iff1` and `iff2`. `di_stb` clears both. `retn_stb` copies `iff2` into `iff1`.
- R3: `im_stb` loads the mode from `im_code`, which is bits 4:3 of the mode-select opcode: 00 and 01 give mode 0, 10 gives mode 1 and 11 gives mode 2.
- R4: A maskable request (`int_n` low) is taken at an accepted boundary only when `iff1` is 1 and `ei_stb` is not asserted at that boundary. Taking it clears both enable flags.
- R5: A boundary with `prefix_ixy` high samples neither request. A pending non-maskable request waits for the next boundary.
- R6: A falling edge on `nmi_n` is latched until serviced. Servicing it clears `iff1`, leaves `iff2` unchanged, runs cycles of 5, 3 and 3 T-states (11 in total) and ends at 0x0066.
- R7: When both requests are present at the same boundary, the non-maskable one is serviced.
- R8: Mode 1 runs 7, 3 and 3 T-states (13 in total) and ends at 0x0038.
- R9: Mode 0 runs 6, 3 and 3 T-states (12 in total). It executes the restart opcode on the bus during the first cycle and ends at that byte AND 0x38.
- R10: Mode 2 runs 7, 3, 3, 3 and 3 T-states (19 in total). It reads the low target byte at {I, bus byte} and then the high byte at that pointer plus 1 (16-bit carry, odd values allowed).
- R11: The two stack-write cycles strobe `push_stb` on their last T-state, first with the return PC high byte and then with the low byte.
- R12: `cyc_kind` is encoded 0 idle, 1 maskable acknowledge, 2 non-maskable opcode read, 3 stack write and 4 vector read. `t_state` counts 1 up to the cycle length and advances by one per clock. `done` pulses with `target_pc` in the clock after the last T-state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_end | input | 1 | Last machine cycle of an instruction ends this clock |
| prefix_ixy | input | 1 | The finished byte was an index-register prefix |
| ei_stb | input | 1 | Enable-interrupts command |
| di_stb | input | 1 | Disable-interrupts command |
| retn_stb | input | 1 | Return-from-interrupt command (copies iff2 to iff1) |
| im_stb | input | 1 | Mode-select command |
| im_code | input | 2 | Opcode bits 4:3 of the mode-select command |
| int_n | input | 1 | Level-sensitive maskable request, active low |
| nmi_n | input | 1 | Edge-latched non-maskable request, active low |
| ireg | input | 8 | Interrupt-vector base register |
| ret_pc | input | 16 | PC to push when a request is taken |
| bus_in | input | 8 | Data bus during acknowledge and vector reads |
| busy | output | 1 | Acknowledge sequence in progress |
| cyc_kind | output | 3 | Current machine-cycle kind |
| t_state | output | 3 | T-state index within the current cycle |
| push_stb | output | 1 | Stack write strobe |
| push_data | output | 8 | Byte being pushed |
| vec_addr | output | 16 | Vector table address for mode 2 reads |
| vec_rd_stb | output | 1 | Vector read strobe |
| done | output | 1 | Sequence finished, target valid |
| target_pc | output | 16 | New program counter |
| iff1 | output | 1 | Interrupt-enable flag 1 |
| iff2 | output | 1 | Interrupt-enable flag 2 |
| im_mode | output | 2 | Current interrupt mode |

## Verification
On every cycle the assertions check the enable-flag effects of each acceptance kind and of the return command. They also check that a prefix boundary starts nothing, that stack strobes only occur inside write cycles and that the T-state counter steps by one. Only the bench scenarios can show the per-mode cycle lengths and totals, the pushed byte order, the vector addresses (including the carry from an odd pointer of 0xFF) and the resulting targets. The same holds for the enable shadow and for non-maskable priority and persistence across a prefix.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
  localparam int DW = 8;
  localparam int AW = 2 * DW;
  localparam int TW = 3;
  localparam int IW = 3;

  typedef enum logic [1:0] {SRC_NMI = 2'd0, SRC_IM0 = 2'd1, SRC_IM1 = 2'd2, SRC_IM2 = 2'd3} src_e;
  typedef enum logic [2:0] {CK_IDLE = 3'd0, CK_ACK = 3'd1, CK_NMI = 3'd2,
                            CK_WR = 3'd3, CK_RD = 3'd4} kind_e;

  // length in T-states of machine cycle i of a sequence
  function automatic logic [TW-1:0] m_len(src_e s, logic [IW-1:0] i);
    if (i != '0) return 3'd3;
    case (s)
      SRC_NMI: return 3'd5;
      SRC_IM0: return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  function automatic kind_e m_kind(src_e s, logic [IW-1:0] i);
    if (i == '0) return (s == SRC_NMI) ? CK_NMI : CK_ACK;
    if (i < 3'd3) return CK_WR;
    return CK_RD;
  endfunction

  function automatic logic [IW-1:0] last_idx(src_e s);
    return (s == SRC_IM2) ? 3'd4 : 3'd2;
  endfunction
endpackage

// File: rtl/irq_flags.sv
module irq_flags
  import irq_ack_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ei_stb,
  input  logic       di_stb,
  input  logic       retn_stb,
  input  logic       im_stb,
  input  logic [1:0] im_code,
  input  logic       acc_int,
  input  logic       acc_nmi,
  output logic       iff1,
  output logic       iff2,
  output logic [1:0] im_mode
);
  always_ff @(posedge clk) begin
    if (rst) begin
      iff1    <= 1'b0;
      iff2    <= 1'b0;
      im_mode <= 2'd0;
    end else begin
      if (ei_stb) begin
        iff1 <= 1'b1;
        iff2 <= 1'b1;
      end
      if (di_stb) begin
        iff1 <= 1'b0;
        iff2 <= 1'b0;
      end
      if (retn_stb) iff1 <= iff2;
      if (im_stb) im_mode <= im_code[1] ? (im_code[0] ? 2'd2 : 2'd1) : 2'd0;
      // acceptance overrides commands seen in the same clock
      if (acc_int) begin
        iff1 <= 1'b0;
        iff2 <= 1'b0;
      end
      if (acc_nmi) iff1 <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_nmi_latch.sv
module irq_nmi_latch (
  input  logic clk,
  input  logic rst,
  input  logic nmi_n,
  input  logic take,
  output logic pend
);
  logic nmi_q;
  logic fall;

  assign fall = nmi_q & ~nmi_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      nmi_q <= 1'b1;
      pend  <= 1'b0;
    end else begin
      nmi_q <= nmi_n;
      pend  <= (pend & ~take) | fall;
    end
  end
endmodule

// File: rtl/irq_seq.sv
module irq_seq
  import irq_ack_pkg::*;
(
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  src_e          start_src,
  output logic          busy,
  output src_e          src,
  output logic [IW-1:0] idx,
  output logic [TW-1:0] tcnt,
  output logic          last_t,
  output logic          fin
);
  assign last_t = busy && (tcnt == m_len(src, idx));
  assign fin    = last_t && (idx == last_idx(src));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      src  <= SRC_NMI;
      idx  <= '0;
      tcnt <= '0;
    end else if (!busy) begin
      if (start) begin
        busy <= 1'b1;
        src  <= start_src;
        idx  <= '0;
        tcnt <= 3'd1;
      end
    end else if (last_t) begin
      if (fin) begin
        busy <= 1'b0;
        tcnt <= '0;
        idx  <= '0;
      end else begin
        idx  <= idx + 3'd1;
        tcnt <= 3'd1;
      end
    end else begin
      tcnt <= tcnt + 3'd1;
    end
  end
endmodule

// File: rtl/irq_vec.sv
module irq_vec
  import irq_ack_pkg::*;
#(
  parameter logic [15:0] NMI_VEC = 16'h0066,
  parameter logic [15:0] RST_VEC = 16'h0038
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [DW-1:0] ireg,
  input  logic [AW-1:0] ret_pc,
  input  logic [DW-1:0] bus_in,
  input  src_e          src,
  input  kind_e         kind,
  input  logic [IW-1:0] idx,
  input  logic          last_t,
  input  logic          fin,
  output logic [DW-1:0] push_data,
  output logic [AW-1:0] vec_addr,
  output logic          done,
  output logic [AW-1:0] target_pc
);
  logic [AW-1:0] pc_q;
  logic [DW-1:0] ibase;
  logic [DW-1:0] ptr_lo;
  logic [DW-1:0] tgt_lo;
  logic [AW-1:0] nxt_tgt;

  assign push_data = (idx == 3'd1) ? pc_q[AW-1:DW] : pc_q[DW-1:0];
  assign vec_addr  = {ibase, ptr_lo} + {{(AW-1){1'b0}}, (idx == 3'd4)};

  always_comb begin
    case (src)
      SRC_NMI: nxt_tgt = NMI_VEC;
      SRC_IM1: nxt_tgt = RST_VEC;
      SRC_IM0: nxt_tgt = {{DW{1'b0}}, ptr_lo & 8'h38};
      default: nxt_tgt = {bus_in, tgt_lo};
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      ibase     <= '0;
      ptr_lo    <= '0;
      tgt_lo    <= '0;
      done      <= 1'b0;
      target_pc <= '0;
    end else begin
      done <= fin;
      if (start) begin
        pc_q  <= ret_pc;
        ibase <= ireg;
      end
      if (last_t && kind == CK_ACK) ptr_lo <= bus_in;
      if (last_t && kind == CK_RD && idx == 3'd3) tgt_lo <= bus_in;
      if (fin) target_pc <= nxt_tgt;
    end
  end
endmodule

// File: rtl/irq_ack_seq.sv
module irq_ack_seq
  import irq_ack_pkg::*;
#(
  parameter logic [15:0] NMI_VEC = 16'h0066,
  parameter logic [15:0] RST_VEC = 16'h0038
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          instr_end,
  input  logic          prefix_ixy,
  input  logic          ei_stb,
  input  logic          di_stb,
  input  logic          retn_stb,
  input  logic          im_stb,
  input  logic [1:0]    im_code,
  input  logic          int_n,
  input  logic          nmi_n,
  input  logic [7:0]    ireg,
  input  logic [15:0]   ret_pc,
  input  logic [7:0]    bus_in,
  output logic          busy,
  output logic [2:0]    cyc_kind,
  output logic [2:0]    t_state,
  output logic          push_stb,
  output logic [7:0]    push_data,
  output logic [15:0]   vec_addr,
  output logic          vec_rd_stb,
  output logic          done,
  output logic [15:0]   target_pc,
  output logic          iff1,
  output logic          iff2,
  output logic [1:0]    im_mode
);
  logic          nmi_pend;
  logic          bnd_ok;
  logic          acc_nmi;
  logic          acc_int;
  logic          acc_any;
  src_e          start_src;
  src_e          src;
  kind_e         kind;
  logic [IW-1:0] idx;
  logic [TW-1:0] tcnt;
  logic          last_t;
  logic          fin;

  assign bnd_ok  = instr_end && !prefix_ixy && !busy;
  assign acc_nmi = bnd_ok && nmi_pend;
  assign acc_int = bnd_ok && !nmi_pend && iff1 && !int_n && !ei_stb;
  assign acc_any = acc_nmi || acc_int;

  always_comb begin
    if (acc_nmi) start_src = SRC_NMI;
    else case (im_mode)
      2'd1:    start_src = SRC_IM1;
      2'd2:    start_src = SRC_IM2;
      default: start_src = SRC_IM0;
    endcase
  end

  irq_flags u_flags (
    .clk(clk), .rst(rst), .ei_stb(ei_stb), .di_stb(di_stb), .retn_stb(retn_stb),
    .im_stb(im_stb), .im_code(im_code), .acc_int(acc_int), .acc_nmi(acc_nmi),
    .iff1(iff1), .iff2(iff2), .im_mode(im_mode)
  );

  irq_nmi_latch u_nmi (
    .clk(clk), .rst(rst), .nmi_n(nmi_n), .take(acc_nmi), .pend(nmi_pend)
  );

  irq_seq u_seq (
    .clk(clk), .rst(rst), .start(acc_any), .start_src(start_src), .busy(busy),
    .src(src), .idx(idx), .tcnt(tcnt), .last_t(last_t), .fin(fin)
  );

  assign kind = busy ? m_kind(src, idx) : CK_IDLE;

  irq_vec #(.NMI_VEC(NMI_VEC), .RST_VEC(RST_VEC)) u_vec (
    .clk(clk), .rst(rst), .start(acc_any), .ireg(ireg), .ret_pc(ret_pc),
    .bus_in(bus_in), .src(src), .kind(kind), .idx(idx), .last_t(last_t), .fin(fin),
    .push_data(push_data), .vec_addr(vec_addr), .done(done), .target_pc(target_pc)
  );

  assign cyc_kind   = kind;
  assign t_state    = busy ? tcnt : 3'd0;
  assign push_stb   = last_t && (kind == CK_WR);
  assign vec_rd_stb = last_t && (kind == CK_RD);
endmodule

// File: rtl/irq_ack_seq_chk.sv
module irq_ack_seq_chk (
  input logic       clk,
  input logic       rst,
  input logic       instr_end,
  input logic       prefix_ixy,
  input logic       ei_stb,
  input logic       di_stb,
  input logic       retn_stb,
  input logic       acc_int,
  input logic       acc_nmi,
  input logic       busy,
  input logic [2:0] cyc_kind,
  input logic [2:0] t_state,
  input logic       push_stb,
  input logic       iff1,
  input logic       iff2
);
  // R4
  int_clears_iff_chk: assert property (@(posedge clk) disable iff (rst)
    acc_int |=> (!iff1 && !iff2));
  // R4
  int_needs_iff1_chk: assert property (@(posedge clk) disable iff (rst)
    acc_int |-> iff1);
  // R6
  nmi_keeps_iff2_chk: assert property (@(posedge clk) disable iff (rst)
    acc_nmi && !ei_stb && !di_stb && !retn_stb |=> (!iff1 && iff2 == $past(iff2)));
  // R5
  prefix_blocks_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && instr_end && prefix_ixy) |=> !busy);
  // R2
  retn_copy_chk: assert property (@(posedge clk) disable iff (rst)
    (retn_stb && !acc_int && !acc_nmi && !ei_stb && !di_stb) |=> (iff1 == $past(iff2)));
  // R11
  push_in_write_chk: assert property (@(posedge clk) disable iff (rst)
    push_stb |-> (busy && cyc_kind == 3'd3));
  // R12
  tstate_step_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && t_state != 3'd1) |-> (t_state == $past(t_state) + 3'd1));
  // R12
  idle_outputs_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (cyc_kind == 3'd0 && t_state == 3'd0));
endmodule

bind irq_ack_seq irq_ack_seq_chk u_chk (
  .clk(clk), .rst(rst), .instr_end(instr_end), .prefix_ixy(prefix_ixy),
  .ei_stb(ei_stb), .di_stb(di_stb), .retn_stb(retn_stb), .acc_int(acc_int),
  .acc_nmi(acc_nmi), .busy(busy), .cyc_kind(cyc_kind), .t_state(t_state),
  .push_stb(push_stb), .iff1(iff1), .iff2(iff2)
);

// File: tb/irq_ack_seq_bench.sv
`timescale 1ns/1ps
module irq_ack_seq_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic instr_end = 0, prefix_ixy = 0, ei_stb = 0, di_stb = 0, retn_stb = 0, im_stb = 0;
  logic [1:0] im_code = 0;
  logic int_n = 1, nmi_n = 1;
  logic [7:0] ireg = 0, bus_in, ack_byte = 8'hFF;
  logic [15:0] ret_pc = 0;
  logic busy, push_stb, vec_rd_stb, done, iff1, iff2;
  logic [2:0] cyc_kind, t_state;
  logic [7:0] push_data;
  logic [15:0] vec_addr, target_pc;
  logic [1:0] im_mode;

  int n_chk = 0, n_bad = 0;
  int tot, ncy, m1, np, nr;
  logic [7:0] pb [2];
  logic [15:0] ra [2];
  logic got_done;
  logic [15:0] got_tgt;

  always #2.5 clk = ~clk;

  irq_ack_seq u_irq_ack_seq (
    .clk(clk), .rst(rst), .instr_end(instr_end), .prefix_ixy(prefix_ixy),
    .ei_stb(ei_stb), .di_stb(di_stb), .retn_stb(retn_stb), .im_stb(im_stb),
    .im_code(im_code), .int_n(int_n), .nmi_n(nmi_n), .ireg(ireg), .ret_pc(ret_pc),
    .bus_in(bus_in), .busy(busy), .cyc_kind(cyc_kind), .t_state(t_state),
    .push_stb(push_stb), .push_data(push_data), .vec_addr(vec_addr),
    .vec_rd_stb(vec_rd_stb), .done(done), .target_pc(target_pc),
    .iff1(iff1), .iff2(iff2), .im_mode(im_mode)
  );

  function automatic logic [7:0] memf(logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
  endfunction

  always_comb bus_in = (cyc_kind == 3'd4) ? memf(vec_addr) : ack_byte;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input bit ie, input bit pf, input bit e, input bit d, input bit r,
                      input bit m, input logic [1:0] code);
    instr_end = ie; prefix_ixy = pf; ei_stb = e; di_stb = d; retn_stb = r;
    im_stb = m; im_code = code;
    @(negedge clk);
    instr_end = 0; prefix_ixy = 0; ei_stb = 0; di_stb = 0; retn_stb = 0; im_stb = 0;
  endtask

  task automatic nmi_pulse();
    nmi_n = 0; @(negedge clk); nmi_n = 1; @(negedge clk);
  endtask

  task automatic measure();
    tot = 0; ncy = 0; m1 = 0; np = 0; nr = 0;
    while (busy && tot < 64) begin
      tot++;
      if (t_state == 3'd1) ncy++;
      if (cyc_kind == 3'd1 || cyc_kind == 3'd2) m1++;
      if (push_stb) begin if (np < 2) pb[np] = push_data; np++; end
      if (vec_rd_stb) begin if (nr < 2) ra[nr] = vec_addr; nr++; end
      @(negedge clk);
    end
    got_done = done; got_tgt = target_pc;
  endtask

  // src: 0 nmi, 1 mode0, 2 mode1, 3 mode2
  task automatic check_ack(input string tag, input int src, input logic [15:0] pc,
                           input logic [15:0] exp_tgt);
    int et, ec, em;
    case (src)
      0: begin et = 11; ec = 3; em = 5; end
      1: begin et = 12; ec = 3; em = 6; end
      2: begin et = 13; ec = 3; em = 7; end
      default: begin et = 19; ec = 5; em = 7; end
    endcase
    chk(tot == et, {tag, " total T"}, tot, et);
    chk(ncy == ec, {tag, " R12 cycles"}, ncy, ec);
    chk(m1 == em, {tag, " first cycle T"}, m1, em);
    chk(np == 2 && pb[0] == pc[15:8] && pb[1] == pc[7:0], {tag, " R11 push"},
        {pb[0], pb[1]}, pc);
    chk(got_done && got_tgt == exp_tgt, {tag, " R12 target"}, got_tgt, exp_tgt);
  endtask

  task automatic take_int(input string tag, input int src, input logic [7:0] iv,
                          input logic [7:0] bv, input logic [15:0] pc);
    logic [15:0] p, e;
    ireg = iv; ack_byte = bv; ret_pc = pc;
    step(1, 0, 1, 0, 0, 0, 0);
    int_n = 0;
    step(1, 0, 0, 0, 0, 0, 0);
    chk(busy == 1'b1, {tag, " R4 accepted"}, busy, 1);
    int_n = 1;
    measure();
    p = {iv, bv};
    case (src)
      1: e = {8'h00, bv & 8'h38};
      2: e = 16'h0038;
      default: e = {memf(p + 16'd1), memf(p)};
    endcase
    check_ack(tag, src, pc, e);
    if (src == 3)
      chk(nr == 2 && ra[0] == p && ra[1] == p + 16'd1, {tag, " R10 addr"}, ra[1], p + 16'd1);
    chk(!iff1 && !iff2, {tag, " R4 flags"}, {iff1, iff2}, 0);
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1
    chk(!iff1 && !iff2 && im_mode == 0 && !busy && cyc_kind == 0 && t_state == 0,
        "R1 reset", {iff1, iff2, im_mode, busy}, 0);

    // R4: disabled, request ignored
    int_n = 0;
    step(1, 0, 0, 0, 0, 0, 0);
    chk(!busy, "R4 disabled no accept", busy, 0);
    // R2 + EI shadow (R4)
    step(1, 0, 1, 0, 0, 0, 0);
    chk(iff1 && iff2, "R2 ei sets", {iff1, iff2}, 3);
    chk(!busy, "R4 ei shadow", busy, 0);
    // R5 prefix boundary
    step(1, 1, 0, 0, 0, 0, 0);
    chk(!busy, "R5 prefix no sample", busy, 0);
    // mode 0 with restart 0x18
    ack_byte = 8'hDF; ret_pc = 16'hA1B2;
    step(1, 0, 0, 0, 0, 0, 0);
    chk(busy, "R9 accept", busy, 1);
    int_n = 1;
    measure();
    check_ack("R9 mode0", 1, 16'hA1B2, 16'h0018);
    chk(!iff1 && !iff2, "R4 clears", {iff1, iff2}, 0);

    // R3 mode selection
    for (int c = 0; c < 4; c++) begin
      step(0, 0, 0, 0, 0, 1, c[1:0]);
      chk(im_mode == ((c < 2) ? 2'd0 : (c == 2 ? 2'd1 : 2'd2)), "R3 mode", im_mode, c);
    end

    // R7: both pending, NMI wins; R6 iff2 kept
    step(1, 0, 1, 0, 0, 1, 2'b10);
    nmi_pulse();
    int_n = 0; ret_pc = 16'h3344;
    step(1, 0, 0, 0, 0, 0, 0);
    int_n = 1;
    measure();
    check_ack("R7 R6 nmi", 0, 16'h3344, 16'h0066);
    chk(!iff1 && iff2, "R6 iff2 kept", {iff1, iff2}, 1);
    step(1, 0, 0, 0, 1, 0, 0);
    chk(iff1, "R2 retn copy", iff1, 1);

    // R5 NMI held across prefix
    nmi_pulse();
    step(1, 1, 0, 0, 0, 0, 0);
    chk(!busy, "R5 nmi waits", busy, 0);
    ret_pc = 16'h0102;
    step(1, 0, 0, 0, 0, 0, 0);
    measure();
    check_ack("R5 nmi later", 0, 16'h0102, 16'h0066);

    // R8 mode 1
    step(0, 0, 0, 0, 0, 1, 2'b10);
    take_int("R8 mode1", 2, 8'h00, 8'h00, 16'hBEEF);
    // R10 mode 2 odd pointer with carry
    step(0, 0, 0, 0, 0, 1, 2'b11);
    take_int("R10 mode2", 3, 8'h12, 8'hFF, 16'h7654);

    // R2 DI
    step(1, 0, 1, 0, 0, 0, 0);
    step(1, 0, 0, 1, 0, 0, 0);
    chk(!iff1 && !iff2, "R2 di clears", {iff1, iff2}, 0);

    // random mix
    for (int i = 0; i < 30; i++) begin
      int s;
      logic [15:0] pc;
      s = int'($urandom % 4);
      pc = 16'($urandom);
      if (s == 0) begin
        nmi_pulse();
        ret_pc = pc;
        step(1, 0, 0, 0, 0, 0, 0);
        measure();
        check_ack("R6 rand nmi", 0, pc, 16'h0066);
        step(0, 0, 0, 0, 1, 0, 0);
      end else begin
        logic [1:0] code;
        logic [7:0] bv;
        code = (s == 1) ? {1'b0, 1'($urandom)} : (s == 2 ? 2'b10 : 2'b11);
        step(0, 0, 0, 0, 0, 1, code);
        bv = (s == 1) ? (8'hC7 | {2'b00, 3'($urandom), 3'b000}) : 8'($urandom);
        take_int("R3 R8 R9 R10 rand", s, 8'($urandom), bv, pc);
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule